// File: doc/BRIEF.md
# Pulse Generator Configuration Register Bank

This block is the software-visible register file that sits in front of a multi-channel pulse generator. A simple single-cycle bus carries a word address, write data, a write enable and a read data return. The bank holds identification words, a scratch word, a control word and, for each channel, a period, a width and an offset. All values are counted in generator clock cycles.

Writes to channel registers land in a staged copy, and the generator never sees them directly. When software sets the load bit in the control word, the whole staged set is copied into the active set in one clock edge. At that same edge a single-cycle load strobe goes to the generator. The active set starts from parameter defaults, so the generator can run before software loads anything. The control word also carries a soft reset level that is passed straight to the generator.

The address port is a word index, so byte offset = 4 × index. Reads are combinational from the current address.

Top module: `pwm_cfg_regs`

## Requirements
- R1: Word index 0 (byte 0x00) always reads 0x00010100, and writes to it change nothing.
- R2: Word index 1 (byte 0x04) reads the INST_ID parameter. Word index 3 (byte 0x0C) reads the constant 0x504C5347.
- R3: Word index 2 (byte 0x08) is a 32-bit read/write scratch word that reads 0 after reset.
- R4: In the control word at index 4 (byte 0x10), bit 0 is a read/write soft reset. It resets to 0, and after a control write `soft_rst` follows the written bit from the next clock edge.
- R5: Writing control bit 1 as 1 copies every staged channel value into the active outputs at that clock edge. `load_pulse` is high for exactly the one cycle after that edge. Bit 1 always reads back as 0.
- R6: Word index 5 (byte 0x14) reads N_CH.
- R7: Channel n uses index 16+3n for period, 17+3n for width and 18+3n for offset (bytes 0x40+12n, 0x44+12n, 0x48+12n). These words read back the staged value, and writing them leaves the active outputs unchanged until a load.
- R8: After reset every staged word reads 0. Every active channel outputs DEF_PERIOD, DEF_WIDTH and DEF_OFFSET.
- R9: Unmapped indices read 0, including the words of channels at or above N_CH. Writes to unmapped or read-only indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | AW | Word index |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read of the word at `addr` |
| soft_rst | output | 1 | Soft reset level to the generator |
| load_pulse | output | 1 | One-cycle strobe marking an active-set update |
| act_period | output | 32·N_CH | Active periods, channel n at bits [32n+31:32n] |
| act_width | output | 32·N_CH | Active widths, same packing |
| act_offset | output | 32·N_CH | Active offsets, same packing |

## Verification
Read data depends only on the current address and stored state. A write becomes visible in `rd_data` in the cycle after its clock edge. `soft_rst`, `load_pulse` and the active outputs all change at the edge that samples the control write, and `load_pulse` falls at the following edge. The bench therefore drives each access just after a falling edge, lets one rising edge pass, and samples every result at the next falling edge. It takes one further cycle to see the strobe drop.

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int          N_CH       = 4,
  parameter logic [31:0] INST_ID    = 32'h0,
  parameter logic [31:0] DEF_PERIOD = 32'd10,
  parameter logic [31:0] DEF_WIDTH  = 32'd7,
  parameter logic [31:0] DEF_OFFSET = 32'd0,
  parameter int          AW         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data,
  output logic              soft_rst,
  output logic              load_pulse,
  output logic [32*N_CH-1:0] act_period,
  output logic [32*N_CH-1:0] act_width,
  output logic [32*N_CH-1:0] act_offset
);
  localparam logic [31:0]   VERSION = 32'h0001_0100;
  localparam logic [31:0]   MAGIC   = 32'h504C_5347;
  localparam logic [AW-1:0] A_VER   = AW'(0);
  localparam logic [AW-1:0] A_ID    = AW'(1);
  localparam logic [AW-1:0] A_SCR   = AW'(2);
  localparam logic [AW-1:0] A_MAG   = AW'(3);
  localparam logic [AW-1:0] A_CTL   = AW'(4);
  localparam logic [AW-1:0] A_NCH   = AW'(5);
  localparam int            CH_BASE = 16;

  logic [31:0] scratch;
  logic [31:0] stg_per [N_CH];
  logic [31:0] stg_wid [N_CH];
  logic [31:0] stg_off [N_CH];

  wire ctl_wr = wr_en && (addr == A_CTL);
  wire do_load = ctl_wr && wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scratch    <= '0;
      soft_rst   <= 1'b0;
      load_pulse <= 1'b0;
    end else begin
      if (wr_en && addr == A_SCR) scratch <= wdata;
      if (ctl_wr) soft_rst <= wdata[0];
      load_pulse <= do_load;
    end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [AW-1:0] A_P = AW'(CH_BASE + 3*g);
    localparam logic [AW-1:0] A_W = AW'(CH_BASE + 3*g + 1);
    localparam logic [AW-1:0] A_O = AW'(CH_BASE + 3*g + 2);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        stg_per[g] <= '0;
        stg_wid[g] <= '0;
        stg_off[g] <= '0;
        act_period[32*g +: 32] <= DEF_PERIOD;
        act_width [32*g +: 32] <= DEF_WIDTH;
        act_offset[32*g +: 32] <= DEF_OFFSET;
      end else begin
        if (wr_en && addr == A_P) stg_per[g] <= wdata;
        if (wr_en && addr == A_W) stg_wid[g] <= wdata;
        if (wr_en && addr == A_O) stg_off[g] <= wdata;
        if (do_load) begin
          act_period[32*g +: 32] <= stg_per[g];
          act_width [32*g +: 32] <= stg_wid[g];
          act_offset[32*g +: 32] <= stg_off[g];
        end
      end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_VER:   rd_data = VERSION;
      A_ID:    rd_data = INST_ID;
      A_SCR:   rd_data = scratch;
      A_MAG:   rd_data = MAGIC;
      A_CTL:   rd_data = {31'b0, soft_rst};
      A_NCH:   rd_data = 32'(N_CH);
      default: rd_data = '0;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (addr == AW'(CH_BASE + 3*i))     rd_data = stg_per[i];
      if (addr == AW'(CH_BASE + 3*i + 1)) rd_data = stg_wid[i];
      if (addr == AW'(CH_BASE + 3*i + 2)) rd_data = stg_off[i];
    end
  end
endmodule

// File: rtl/pwm_cfg_regs_chk.sv
module pwm_cfg_regs_chk #(
  parameter int N_CH = 4,
  parameter int AW   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [AW-1:0]      addr,
  input logic [31:0]        wdata,
  input logic [31:0]        rd_data,
  input logic               soft_rst,
  input logic               load_pulse,
  input logic [32*N_CH-1:0] act_period,
  input logic [32*N_CH-1:0] act_width,
  input logic [32*N_CH-1:0] act_offset
);
  assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr == AW'(0) |-> rd_data == 32'h0001_0100);

  assert_magic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr == AW'(3) |-> rd_data == 32'h504C_5347);

  assert_softrst_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(soft_rst) |-> $past(wr_en && addr == AW'(4)));

  assert_load_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> $past(wr_en && addr == AW'(4) && wdata[1]));

  assert_ctl_bit1_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr == AW'(4) |-> rd_data[31:1] == '0);

  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |-> ($stable(act_period) && $stable(act_width) && $stable(act_offset)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > AW'(5) && addr < AW'(16)) |-> rd_data == '0);
endmodule

bind pwm_cfg_regs pwm_cfg_regs_chk #(.N_CH(N_CH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rd_data(rd_data), .soft_rst(soft_rst), .load_pulse(load_pulse),
  .act_period(act_period), .act_width(act_width), .act_offset(act_offset));

// File: tb/pwm_cfg_regs_tb.sv
module pwm_cfg_regs_tb;
  localparam int N_CH = 3;
  localparam int AW   = 6;
  localparam int NV   = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic soft_rst, load_pulse;
  logic [32*N_CH-1:0] act_period, act_width, act_offset;
  int checks = 0;
  int errs = 0;

  always #2 clk = ~clk;

  pwm_cfg_regs #(.N_CH(N_CH), .INST_ID(32'h5A), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .soft_rst(soft_rst), .load_pulse(load_pulse),
    .act_period(act_period), .act_width(act_width), .act_offset(act_offset));

  // {req, we, addr, wdata, expected read}
  localparam logic [74:0] VEC [NV] = '{
    {4'd1, 1'b0, 6'h00, 32'h0,        32'h0001_0100}, // R1
    {4'd1, 1'b1, 6'h00, 32'hFFFF_FFFF, 32'h0001_0100}, // R1
    {4'd2, 1'b0, 6'h01, 32'h0,        32'h0000_005A}, // R2
    {4'd2, 1'b0, 6'h03, 32'h0,        32'h504C_5347}, // R2
    {4'd3, 1'b1, 6'h02, 32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R3
    {4'd6, 1'b0, 6'h05, 32'h0,        32'd3},         // R6
    {4'd7, 1'b1, 6'h10, 32'd20,       32'd20},        // R7
    {4'd7, 1'b1, 6'h11, 32'd5,        32'd5},         // R7
    {4'd7, 1'b1, 6'h14, 32'd3,        32'd3},         // R7
    {4'd9, 1'b1, 6'h19, 32'd99,       32'd0},         // R9
    {4'd9, 1'b0, 6'h07, 32'h0,        32'd0},         // R9
    {4'd4, 1'b1, 6'h04, 32'd1,        32'd1},         // R4
    {4'd9, 1'b1, 6'h05, 32'd7,        32'd3},         // R9
    {4'd9, 1'b0, 6'h3F, 32'h0,        32'd0}          // R9
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 / reset state
    chk(8, {31'b0, soft_rst}, 32'd0);
    chk(8, {31'b0, load_pulse}, 32'd0);
    addr = 6'h02; #0.1; chk(3, rd_data, 32'd0);
    addr = 6'h10; #0.1; chk(8, rd_data, 32'd0);
    chk(8, act_period[31:0], 32'd10);
    chk(8, act_width[95:64], 32'd7);
    chk(8, act_offset[63:32], 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][70], VEC[i][69:64], VEC[i][63:32]);
      chk(int'(VEC[i][74:71]), rd_data, VEC[i][31:0]);
    end

    // R7: staged writes did not reach the active outputs
    chk(7, act_period[31:0], 32'd10);
    chk(7, act_width[31:0], 32'd7);
    chk(7, act_width[63:32], 32'd7);

    // R5: load with soft reset held
    access(1'b1, 6'h04, 32'd3);
    chk(5, {31'b0, load_pulse}, 32'd1);
    chk(5, rd_data, 32'd1);
    chk(5, act_period[31:0], 32'd20);
    chk(5, act_width[31:0], 32'd5);
    chk(5, act_width[63:32], 32'd3);
    chk(5, act_period[95:64], 32'd0);
    chk(4, {31'b0, soft_rst}, 32'd1);
    @(negedge clk);
    chk(5, {31'b0, load_pulse}, 32'd0);

    // R4: clear soft reset without loading
    access(1'b1, 6'h10, 32'd44);
    access(1'b1, 6'h04, 32'd0);
    chk(4, {31'b0, soft_rst}, 32'd0);
    chk(5, {31'b0, load_pulse}, 32'd0);
    chk(7, act_period[31:0], 32'd20);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule